// File: doc/BRIEF.md
# Sector Memory With Value Transfer Buffer

The block holds a 1 KiB memory arranged as 16 sectors, each of four 16-byte blocks. A requester issues one command at a time: an operation code, a block number, a 128-bit write image and a 32-bit operand. Exactly one cycle later the block answers with a status code and, for reads, the block contents. The memory is a reset-initialised register array. Block 0 comes out of reset with a fixed manufacturer pattern and can never be changed.

Arithmetic never writes memory directly. Increment, decrement and restore read a value block and leave their result in an internal transfer buffer. Only an explicit transfer command copies that buffer into a target value block. The last block of every sector is its trailer. A trailer holds a hidden key, a lock field and a second key area. The lock field decides which blocks of that sector may be read or written.

Top module: `sector_vault`

## Requirements
- R1: After reset, rsp_valid is 0. Block 0 holds the MFG_WORD parameter and every other block is all zeros, so every lock is open. The transfer buffer is empty.
- R2: Each cycle with req_valid high yields rsp_valid high on the next cycle, and only then. Operation codes are 0 read, 1 write, 2 increment, 3 decrement, 4 restore and 5 transfer. Codes 6 and 7 are answered with status 1. Status codes are 0 done, 1 denied, 2 bad value format and 3 buffer empty.
- R3: Byte i of a block lies on bits 8i+7:8i. A successful read returns the stored block. Every response other than a successful read carries all-zero data.
- R4: A write or transfer aimed at block 0 is denied, and block 0 keeps its content.
- R5: Trailer bytes 0-5 hold key A, byte 6 holds the read-lock mask, byte 7 holds the write-lock mask, and bytes 8-15 hold key B. A write may replace the whole trailer. A read of a trailer returns zeros in bytes 0-5 and the stored value in the other bytes.
- R6: Let k be the block's position inside its sector (block number mod 4). Bit k of the trailer's byte 6 denies read, increment, decrement and restore of that block. Bit k of byte 7 denies write and transfer into it, and bit 3 of byte 7 freezes the trailer itself.
- R7: A value block holds a 32-bit value V in bytes 0-3, its inverse in bytes 4-7 and V again in bytes 8-11. It holds an address byte A in bytes 12 and 14 and its inverse in bytes 13 and 15. Increment, decrement or restore of a block that breaks this pattern returns status 2 and leaves the transfer buffer as it was.
- R8: Increment and decrement place V plus or minus the operand, modulo 2^32, in the buffer together with the source's A. The source block is left unchanged.
- R9: Restore places the source's V and A in the buffer unchanged.
- R10: Transfer writes a well-formed value block built from the buffer's V and A into the target, and then empties the buffer. A transfer with an empty buffer returns status 3 and writes nothing. A denial takes priority over an empty buffer.
- R11: Increment, decrement, restore or transfer that names a trailer block is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command present this cycle |
| req_op | input | 3 | Operation code |
| req_blk | input | 6 | Block number, sector times 4 plus position |
| req_wdata | input | 128 | Block image for a write |
| req_operand | input | 32 | Amount for increment or decrement |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 2 | Result code |
| rsp_data | output | 128 | Block contents for a read, zero otherwise |

## Verification
The bench builds the block with its default geometry: 16 sectors of 4 blocks. It overrides the manufacturer word with a distinctive pattern, so that a change to block 0 cannot hide among zeros. With four blocks per sector, one trailer can lock a readable block, a writable block and the trailer itself at the same time. The 32-bit value width makes both wrap-around and the reuse of the transfer buffer after a format error reachable in a short vector table.

// File: rtl/sector_vault_pkg.sv
package sector_vault_pkg;
  localparam int BLK_W      = 128;
  localparam int VAL_W      = 32;
  localparam int KEYA_W     = 48;
  localparam int RLOCK_LSB  = 48;
  localparam int WLOCK_LSB  = 56;

  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_WRITE   = 3'd1,
    OP_INC     = 3'd2,
    OP_DEC     = 3'd3,
    OP_RESTORE = 3'd4,
    OP_XFER    = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_DENY   = 2'd1,
    ST_BADVAL = 2'd2,
    ST_NOBUF  = 2'd3
  } st_e;

  // redundancy check of the value-block image
  function automatic logic val_ok(input logic [BLK_W-1:0] b);
    logic [7:0] a;
    a = b[103:96];
    return (b[31:0] == b[95:64]) && (b[63:32] == ~b[31:0]) &&
           (b[119:112] == a) && (b[111:104] == ~a) && (b[127:120] == ~a);
  endfunction

  // build a well-formed value block
  function automatic logic [BLK_W-1:0] val_pack(input logic [VAL_W-1:0] v,
                                                input logic [7:0] a);
    return {~a, a, ~a, a, v, ~v, v};
  endfunction

  // trailer as seen by a reader: key A hidden
  function automatic logic [BLK_W-1:0] trl_view(input logic [BLK_W-1:0] b);
    return {b[BLK_W-1:KEYA_W], {KEYA_W{1'b0}}};
  endfunction

  function automatic logic [VAL_W-1:0] val_apply(input op_e op,
                                                 input logic [VAL_W-1:0] v,
                                                 input logic [VAL_W-1:0] d);
    case (op)
      OP_INC:  return v + d;
      OP_DEC:  return v - d;
      default: return v;
    endcase
  endfunction
endpackage

// File: rtl/sv_store.sv
module sv_store #(
  parameter int NBLK = 64,
  parameter int AW   = 6,
  parameter logic [sector_vault_pkg::BLK_W-1:0] INIT0 = '0
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [AW-1:0]                      waddr,
  input  logic [sector_vault_pkg::BLK_W-1:0] wdata,
  input  logic [AW-1:0]                      raddr_a,
  output logic [sector_vault_pkg::BLK_W-1:0] rdata_a,
  input  logic [AW-1:0]                      raddr_b,
  output logic [sector_vault_pkg::BLK_W-1:0] rdata_b
);
  localparam int BW = sector_vault_pkg::BLK_W;

  logic [BW-1:0] rows [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_row
    localparam logic [BW-1:0] RST_VAL = (g == 0) ? INIT0 : '0;
    logic [BW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            q <= RST_VAL;
      else if (we && (waddr == AW'(g)))      q <= wdata;
    end
    assign rows[g] = q;
  end

  assign rdata_a = rows[raddr_a];
  assign rdata_b = rows[raddr_b];
endmodule

// File: rtl/sv_guard.sv
module sv_guard #(
  parameter int AW  = 6,
  parameter int BPS = 4
) (
  input  sector_vault_pkg::op_e              op,
  input  logic [AW-1:0]                      blk,
  input  logic [sector_vault_pkg::BLK_W-1:0] trl,
  output logic                               is_trl,
  output logic                               deny
);
  import sector_vault_pkg::*;
  localparam int SLOT_W = $clog2(BPS);

  logic [SLOT_W-1:0] slot;
  logic              rd_lock, wr_lock, is_blk0;

  assign slot    = blk[SLOT_W-1:0];
  assign is_trl  = (slot == SLOT_W'(BPS-1));
  assign is_blk0 = (blk == '0);
  assign rd_lock = trl[RLOCK_LSB + int'(slot)];
  assign wr_lock = trl[WLOCK_LSB + int'(slot)];

  always_comb begin
    case (op)
      OP_READ:                    deny = rd_lock;
      OP_WRITE:                   deny = is_blk0 | wr_lock;
      OP_INC, OP_DEC, OP_RESTORE: deny = is_trl | rd_lock;
      OP_XFER:                    deny = is_blk0 | is_trl | wr_lock;
      default:                    deny = 1'b1;
    endcase
  end
endmodule

// File: rtl/sv_alu.sv
module sv_alu (
  input  sector_vault_pkg::op_e              op,
  input  logic [sector_vault_pkg::BLK_W-1:0] src,
  input  logic [sector_vault_pkg::VAL_W-1:0] operand,
  output logic                               fmt_ok,
  output logic [sector_vault_pkg::VAL_W-1:0] res_val,
  output logic [7:0]                         res_addr
);
  import sector_vault_pkg::*;
  assign fmt_ok   = val_ok(src);
  assign res_val  = val_apply(op, src[VAL_W-1:0], operand);
  assign res_addr = src[103:96];
endmodule

// File: rtl/sector_vault.sv
module sector_vault #(
  parameter int SECTORS     = 16,
  parameter int BLK_PER_SEC = 4,
  parameter logic [127:0] MFG_WORD = 128'h4D46_0000_0000_0000_0000_0000_0000_0001,
  localparam int NBLK = SECTORS * BLK_PER_SEC,
  localparam int AW   = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_blk,
  input  logic [127:0]  req_wdata,
  input  logic [31:0]   req_operand,
  output logic          rsp_valid,
  output logic [1:0]    rsp_status,
  output logic [127:0]  rsp_data
);
  import sector_vault_pkg::*;

  op_e              op;
  logic [AW-1:0]    trl_blk;
  logic [BLK_W-1:0] blk_q, trl_q;
  logic             is_trl, deny, fmt_ok;
  logic [VAL_W-1:0] alu_val;
  logic [7:0]       alu_addr;

  // transfer buffer
  logic             tbuf_vld;
  logic [VAL_W-1:0] tbuf_val;
  logic [7:0]       tbuf_addr;

  // named internal events
  logic             wr_en;
  logic [AW-1:0]    wr_blk;
  logic [BLK_W-1:0] wr_data;
  logic             ev_tbuf_load, ev_tbuf_clear;
  st_e              st_d;
  logic [BLK_W-1:0] data_d;

  assign op      = op_e'(req_op);
  assign trl_blk = req_blk | AW'(BLK_PER_SEC - 1);
  assign wr_blk  = req_blk;

  sv_store #(.NBLK(NBLK), .AW(AW), .INIT0(MFG_WORD)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en), .waddr(wr_blk), .wdata(wr_data),
    .raddr_a(req_blk), .rdata_a(blk_q),
    .raddr_b(trl_blk), .rdata_b(trl_q)
  );

  sv_guard #(.AW(AW), .BPS(BLK_PER_SEC)) u_guard (
    .op(op), .blk(req_blk), .trl(trl_q), .is_trl(is_trl), .deny(deny)
  );

  sv_alu u_alu (
    .op(op), .src(blk_q), .operand(req_operand),
    .fmt_ok(fmt_ok), .res_val(alu_val), .res_addr(alu_addr)
  );

  always_comb begin
    st_d          = ST_OK;
    data_d        = '0;
    wr_en         = 1'b0;
    wr_data       = req_wdata;
    ev_tbuf_load  = 1'b0;
    ev_tbuf_clear = 1'b0;
    if (deny) begin
      st_d = ST_DENY;
    end else begin
      case (op)
        OP_READ:  data_d = is_trl ? trl_view(blk_q) : blk_q;
        OP_WRITE: wr_en  = req_valid;
        OP_INC, OP_DEC, OP_RESTORE: begin
          if (!fmt_ok) st_d = ST_BADVAL;
          else         ev_tbuf_load = req_valid;
        end
        OP_XFER: begin
          if (!tbuf_vld) st_d = ST_NOBUF;
          else begin
            wr_en         = req_valid;
            wr_data       = val_pack(tbuf_val, tbuf_addr);
            ev_tbuf_clear = req_valid;
          end
        end
        default: st_d = ST_DENY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= 2'd0;
      rsp_data   <= '0;
      tbuf_vld   <= 1'b0;
      tbuf_val   <= '0;
      tbuf_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_status <= st_d;
        rsp_data   <= data_d;
      end
      if (ev_tbuf_load) begin
        tbuf_vld  <= 1'b1;
        tbuf_val  <= alu_val;
        tbuf_addr <= alu_addr;
      end else if (ev_tbuf_clear) begin
        tbuf_vld  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sector_vault_chk.sv
module sector_vault_chk #(
  parameter int AW     = 6,
  parameter int SLOT_W = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [2:0]    req_op,
  input logic [AW-1:0] req_blk,
  input logic          rsp_valid,
  input logic [1:0]    rsp_status,
  input logic [127:0]  rsp_data,
  input logic          wr_en,
  input logic [AW-1:0] wr_blk,
  input logic          tbuf_vld
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R4
  blk0_never_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_blk != '0));
  // R3
  fail_rsp_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'd0) |-> (rsp_data == '0));
  // R5
  keya_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd0 && req_blk[SLOT_W-1:0] == '1) |=> (rsp_data[47:0] == '0));
  // R10
  empty_xfer_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd5 && !tbuf_vld) |=> (rsp_status != 2'd0));
  // R10
  empty_xfer_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == 3'd5 && !tbuf_vld) |-> !wr_en);
  // R11
  trl_no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == 3'd5 && req_blk[SLOT_W-1:0] == '1) |-> !wr_en);
endmodule

bind sector_vault sector_vault_chk #(.AW(AW), .SLOT_W($clog2(BLK_PER_SEC))) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_blk(req_blk),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
  .wr_en(wr_en), .wr_blk(wr_blk), .tbuf_vld(tbuf_vld)
);

// File: tb/sector_vault_test.sv
module sector_vault_test;
  localparam logic [127:0] MFG = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
  localparam logic [2:0] RD = 3'd0, WR = 3'd1, INC = 3'd2, DEC = 3'd3, RST = 3'd4, XF = 3'd5;
  localparam logic [1:0] OK = 2'd0, DNY = 2'd1, BAD = 2'd2, EMP = 2'd3;

  // value block image written byte by byte
  function automatic logic [127:0] mkval(input logic [31:0] v, input logic [7:0] a);
    logic [127:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b;
      if (i < 4)       b = v[8*i +: 8];
      else if (i < 8)  b = ~v[8*(i-4) +: 8];
      else if (i < 12) b = v[8*(i-8) +: 8];
      else             b = (i % 2 == 0) ? a : ~a;
      r[8*i +: 8] = b;
    end
    return r;
  endfunction

  localparam logic [127:0] TRL  = {64'h0123_4567_89AB_CDEF, 8'h01, 8'h02, 48'hA1A2_A3A4_A5A6};
  localparam logic [127:0] TRLV = {64'h0123_4567_89AB_CDEF, 8'h01, 8'h02, 48'h0};
  localparam logic [127:0] TRL2 = {64'h0, 8'h08, 8'h00, 48'h0};

  typedef struct packed {
    logic [2:0]   op;
    logic [5:0]   blk;
    logic [127:0] wd;
    logic [31:0]  opd;
    logic [1:0]   st;
    logic [127:0] rd;
    logic [23:0]  tag;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VEC [NV] = '{
    '{RD,  6'd0,  128'h0, 32'd0,   OK,  MFG, "R3"},
    '{WR,  6'd0,  128'hDEAD, 32'd0, DNY, 128'h0, "R4"},
    '{RD,  6'd0,  128'h0, 32'd0,   OK,  MFG, "R4"},
    '{WR,  6'd4,  mkval(32'd100, 8'd4), 32'd0, OK, 128'h0, "R3"},
    '{RD,  6'd4,  128'h0, 32'd0,   OK,  mkval(32'd100, 8'd4), "R3"},
    '{XF,  6'd5,  128'h0, 32'd0,   EMP, 128'h0, "R10"},
    '{INC, 6'd4,  128'h0, 32'd23,  OK,  128'h0, "R8"},
    '{RD,  6'd4,  128'h0, 32'd0,   OK,  mkval(32'd100, 8'd4), "R8"},
    '{XF,  6'd5,  128'h0, 32'd0,   OK,  128'h0, "R10"},
    '{RD,  6'd5,  128'h0, 32'd0,   OK,  mkval(32'd123, 8'd4), "R8"},
    '{XF,  6'd6,  128'h0, 32'd0,   EMP, 128'h0, "R10"},
    '{RD,  6'd6,  128'h0, 32'd0,   OK,  128'h0, "R10"},
    '{DEC, 6'd4,  128'h0, 32'd101, OK,  128'h0, "R8"},
    '{XF,  6'd6,  128'h0, 32'd0,   OK,  128'h0, "R8"},
    '{RD,  6'd6,  128'h0, 32'd0,   OK,  mkval(32'hFFFF_FFFF, 8'd4), "R8"},
    '{RST, 6'd4,  128'h0, 32'd0,   OK,  128'h0, "R9"},
    '{XF,  6'd8,  128'h0, 32'd0,   OK,  128'h0, "R9"},
    '{RD,  6'd8,  128'h0, 32'd0,   OK,  mkval(32'd100, 8'd4), "R9"},
    '{WR,  6'd9,  128'h1234, 32'd0, OK, 128'h0, "R7"},
    '{INC, 6'd9,  128'h0, 32'd1,   BAD, 128'h0, "R7"},
    '{XF,  6'd9,  128'h0, 32'd0,   EMP, 128'h0, "R7"},
    '{INC, 6'd7,  128'h0, 32'd1,   DNY, 128'h0, "R11"},
    '{XF,  6'd7,  128'h0, 32'd0,   DNY, 128'h0, "R11"},
    '{XF,  6'd0,  128'h0, 32'd0,   DNY, 128'h0, "R4"},
    '{WR,  6'd7,  TRL,    32'd0,   OK,  128'h0, "R5"},
    '{RD,  6'd7,  128'h0, 32'd0,   OK,  TRLV, "R5"},
    '{RD,  6'd5,  128'h0, 32'd0,   DNY, 128'h0, "R6"},
    '{INC, 6'd5,  128'h0, 32'd1,   DNY, 128'h0, "R6"},
    '{WR,  6'd4,  128'h77, 32'd0,  DNY, 128'h0, "R6"},
    '{RD,  6'd4,  128'h0, 32'd0,   OK,  mkval(32'd100, 8'd4), "R6"},
    '{RD,  6'd6,  128'h0, 32'd0,   OK,  mkval(32'hFFFF_FFFF, 8'd4), "R6"},
    '{3'd6, 6'd4, 128'h0, 32'd0,   DNY, 128'h0, "R2"},
    '{3'd7, 6'd4, 128'h0, 32'd0,   DNY, 128'h0, "R2"},
    '{RST, 6'd6,  128'h0, 32'd0,   OK,  128'h0, "R9"},
    '{INC, 6'd9,  128'h0, 32'd5,   BAD, 128'h0, "R7"},
    '{XF,  6'd10, 128'h0, 32'd0,   OK,  128'h0, "R7"},
    '{RD,  6'd10, 128'h0, 32'd0,   OK,  mkval(32'hFFFF_FFFF, 8'd4), "R7"},
    '{WR,  6'd11, TRL2,   32'd0,   OK,  128'h0, "R6"},
    '{WR,  6'd11, 128'h0, 32'd0,   DNY, 128'h0, "R6"},
    '{RD,  6'd11, 128'h0, 32'd0,   OK,  TRL2, "R6"}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [2:0]   req_op = 3'd0;
  logic [5:0]   req_blk = 6'd0;
  logic [127:0] req_wdata = '0;
  logic [31:0]  req_operand = '0;
  logic         rsp_valid;
  logic [1:0]   rsp_status;
  logic [127:0] rsp_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sector_vault #(.MFG_WORD(MFG)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_blk(req_blk), .req_wdata(req_wdata), .req_operand(req_operand),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample the response at the next falling edge
  task automatic issue(input logic [2:0] op, input logic [5:0] blk, input logic [127:0] wd,
                       input logic [31:0] opd, input logic [1:0] st, input logic [127:0] rd,
                       input string tag);
    req_valid = 1'b1; req_op = op; req_blk = blk; req_wdata = wd; req_operand = opd;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"},  {127'b0, rsp_valid}, 128'h1);
    check({tag, " status"}, {126'b0, rsp_status}, {126'b0, st});
    check({tag, " data"},   rsp_data, rd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rsp_valid in reset", {127'b0, rsp_valid}, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {127'b0, rsp_valid}, 128'h0);
    issue(RD, 6'd1, '0, '0, OK, 128'h0, "R1 blk1 zero");
    issue(XF, 6'd5, '0, '0, EMP, 128'h0, "R1 buffer empty");

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].op, VEC[i].blk, VEC[i].wd, VEC[i].opd, VEC[i].st, VEC[i].rd,
            $sformatf("%s vec%0d", VEC[i].tag, i));
    end

    // R2: no response without a request
    @(negedge clk);
    check("R2 no rsp when idle", {127'b0, rsp_valid}, 128'h0);

    // R1: mid-run reset restores initial content
    issue(RST, 6'd4, '0, '0, OK, 128'h0, "R1 buffer load before reset");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    issue(RD, 6'd4, '0, '0, OK, 128'h0, "R1 blk4 cleared");
    issue(RD, 6'd0, '0, '0, OK, MFG, "R1 blk0 pattern");
    issue(RD, 6'd7, '0, '0, OK, 128'h0, "R1 trailer cleared");
    issue(XF, 6'd5, '0, '0, EMP, 128'h0, "R1 buffer emptied");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule